// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block is the interrupt half of a 128-pin general-purpose I/O controller. Every pin delivers an input level that has already been synchronized to the block clock, plus the two configuration fields that matter for interrupts: a 2-bit trigger mode and an 8-bit route-select value. The pad configuration storage lives elsewhere. This block only reads those fields as inputs.

When a pin is allowed to trigger, its activity latches a bit in a status bank. There are four 32-bit status banks and four 32-bit enable banks, reached through a simple 32-bit register bus. Status bits are acknowledged by writing ones to them. Enable bits are plain read/write mask bits.

A single shared interrupt line is driven from a register. It goes high when any pin has both its status bit and its enable bit set. Software then scans the status and enable words to find which pin fired.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: After reset, every status bit and every enable bit reads 0 and `irq_out` is low.
- R2: Pin p lives in bank p/32 at bit p%32. Status word k is at byte address 0x14+4k and enable word k is at 0x24+4k, for k = 0..3. Reads of any other address return 0, and writes to any other address change nothing.
- R3: Trigger mode 0 (level) sets the pin's status bit on every clock edge at which its input is high.
- R4: Trigger mode 1 (rising) sets the status bit only when the input is high and was low one cycle earlier. A steady high input does not set the bit again once it has been cleared.
- R5: Trigger modes 2 and 3 never set the status bit.
- R6: A pin whose 8-bit route-select value is zero never sets its status bit, whatever its mode and input.
- R7: Writing a status word clears each bit written as 1. Bits written as 0 are unchanged.
- R8: If a new trigger and a clear of the same status bit land on the same clock edge, the bit stays set.
- R9: Enable words read back exactly what was last written to them. Clearing an enable bit leaves the matching status bit unchanged.
- R10: `irq_out` equals the OR over all pins of (status AND enable), registered. It changes one clock after the status or enable change that causes it.
- R11: In level mode, a clear written while the input is still high does not take effect. A clear written after the input has fallen does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | 128 | Synchronized input level, one bit per pin |
| pin_trig_mode | input | 256 | Trigger mode per pin, bits [2p+1:2p] |
| pin_route_sel | input | 1024 | Route-select value per pin, bits [8p+7:8p] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next clock |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held between reads |
| irq_out | output | 1 | Shared interrupt request, registered |

## Verification
Status and enable are both readable, so a corrupted bit in either shows up on the next read of its word, one clock after the read strobe.

A wrong pending term shows on `irq_out` exactly one clock after the status or enable change that should have caused it. The bench therefore samples that line in the cycle before the expected change as well as in the cycle of it.

Faulty trigger qualification appears as a status bit that is set when it should not be, or clear when it should be set. This is checked in the same bus read that follows a one-cycle input pulse.

A bad acknowledge path shows as a bit that survives, or disappears after, the write that targeted it.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and types for the GPIO interrupt aggregator.
// Assumes byte addressing with 32-bit words and at most four banks,
// so that the status and enable windows do not overlap.
package gpio_irq_pkg;

    // Trigger mode encoding carried on pin_trig_mode.
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_NONE  = 2'd2,
        TRIG_RSVD  = 2'd3
    } trig_mode_e;

    localparam int STATUS_BASE = 'h14;
    localparam int ENABLE_BASE = 'h24;
    localparam int WORD_BYTES  = 4;

endpackage

// File: rtl/gpio_irq_edge_detect.sv
// Per-pin trigger qualification.
// Produces a one-cycle set request for each pin from its level, its trigger
// mode and its route-select field. Keeps the previous sampled level for
// rising-edge detection. Assumes pin_level is already synchronous to clk.
module gpio_irq_edge_detect
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 128,
    parameter int SEL_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WIDTH-1:0]       level,
    input  logic [2*WIDTH-1:0]     mode,
    input  logic [SEL_W*WIDTH-1:0] route,
    output logic [WIDTH-1:0]       set_req
);

    logic [WIDTH-1:0] prev_level;

    // Remember last cycle's level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_level <= '0;
        else        prev_level <= level;
    end

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        trig_mode_e mode_e;
        logic       route_ok;
        logic       hit;

        assign mode_e   = trig_mode_e'(mode[2*p +: 2]);
        assign route_ok = |route[SEL_W*p +: SEL_W];

        // Decide whether this pin raises its status this cycle.
        always_comb begin
            unique case (mode_e)
                TRIG_LEVEL: hit = level[p];
                TRIG_RISE:  hit = level[p] & ~prev_level[p];
                default:    hit = 1'b0;
            endcase
            set_req[p] = route_ok & hit;
        end
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// One bank of status and enable bits.
// Status bits are write-one-to-clear, and a simultaneous set wins over the
// clear. Enable bits are plain read/write. Assumes at most one write strobe
// per bank per cycle.
module gpio_irq_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_req,
    input  logic             clr_we,
    input  logic             en_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] enable
);

    logic [WIDTH-1:0] clr_mask;

    // Bits to acknowledge this cycle.
    always_comb clr_mask = clr_we ? wdata : '0;

    // Status update: clear first, then apply new triggers so that sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | set_req;
    end

    // Enable word load.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= '0;
        else if (en_we) enable <= wdata;
    end

endmodule

// File: rtl/gpio_irq_regbus.sv
// Register bus decode and read path.
// Turns a write strobe into per-bank status-clear and enable-load strobes,
// and returns the addressed word one cycle after a read strobe. Unmapped
// addresses read as zero. Assumes word-aligned byte addresses.
module gpio_irq_regbus
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [NUM_BANKS*DATA_W-1:0] status_all,
    input  logic [NUM_BANKS*DATA_W-1:0] enable_all,
    output logic [NUM_BANKS-1:0]        st_we,
    output logic [NUM_BANKS-1:0]        en_we,
    output logic [DATA_W-1:0]           rdata
);

    logic [NUM_BANKS-1:0] st_hit;
    logic [NUM_BANKS-1:0] en_hit;
    logic [DATA_W-1:0]    rd_word;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_dec
        localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(STATUS_BASE + WORD_BYTES * k);
        localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(ENABLE_BASE + WORD_BYTES * k);
        assign st_hit[k] = (bus_addr == ST_ADDR);
        assign en_hit[k] = (bus_addr == EN_ADDR);
    end

    assign st_we = st_hit & {NUM_BANKS{bus_wr}};
    assign en_we = en_hit & {NUM_BANKS{bus_wr}};

    // Select the addressed word, zero if nothing matches.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (st_hit[k]) rd_word = rd_word | status_all[k*DATA_W +: DATA_W];
            if (en_hit[k]) rd_word = rd_word | enable_all[k*DATA_W +: DATA_W];
        end
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (bus_rd) rdata <= rd_word;
    end

endmodule

// File: rtl/gpio_irq_aggregator.sv
// Top of the GPIO interrupt aggregator.
// Qualifies pin activity into status banks, masks them with the enable
// banks and drives one registered shared interrupt line. Assumes NUM_PINS
// is a multiple of BANK_W and that there are at most four banks.
module gpio_irq_aggregator #(
    parameter int NUM_PINS = 128,
    parameter int BANK_W   = 32,
    parameter int SEL_W    = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       pin_level,
    input  logic [2*NUM_PINS-1:0]     pin_trig_mode,
    input  logic [SEL_W*NUM_PINS-1:0] pin_route_sel,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [BANK_W-1:0]         bus_wdata,
    output logic [BANK_W-1:0]         bus_rdata,
    output logic                      irq_out
);

    localparam int NUM_BANKS = NUM_PINS / BANK_W;

    logic [NUM_PINS-1:0]  set_req;
    logic [NUM_PINS-1:0]  status_all;
    logic [NUM_PINS-1:0]  enable_all;
    logic [NUM_BANKS-1:0] st_we;
    logic [NUM_BANKS-1:0] en_we;
    logic                 irq_q;

    gpio_irq_edge_detect #(
        .WIDTH (NUM_PINS),
        .SEL_W (SEL_W)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (pin_level),
        .mode    (pin_trig_mode),
        .route   (pin_route_sel),
        .set_req (set_req)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        gpio_irq_bank #(
            .WIDTH (BANK_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_req[k*BANK_W +: BANK_W]),
            .clr_we  (st_we[k]),
            .en_we   (en_we[k]),
            .wdata   (bus_wdata),
            .status  (status_all[k*BANK_W +: BANK_W]),
            .enable  (enable_all[k*BANK_W +: BANK_W])
        );
    end

    gpio_irq_regbus #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (BANK_W),
        .ADDR_W    (ADDR_W)
    ) u_regbus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .status_all (status_all),
        .enable_all (enable_all),
        .st_we      (st_we),
        .en_we      (en_we),
        .rdata      (bus_rdata)
    );

    // Register the OR of all pending (status and enabled) bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_all & enable_all);
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/gpio_irq_aggregator_sva.sv
// Protocol checker for the GPIO interrupt aggregator, attached by bind.
// Observes ports and the internal status and enable vectors only.
module gpio_irq_aggregator_sva
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 128,
    parameter int BANK_W   = 32,
    parameter int SEL_W    = 8,
    parameter int ADDR_W   = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      irq_out,
    input logic [NUM_PINS-1:0]       status_all,
    input logic [NUM_PINS-1:0]       enable_all,
    input logic [2*NUM_PINS-1:0]     pin_trig_mode,
    input logic [SEL_W*NUM_PINS-1:0] pin_route_sel
);

    localparam int NUM_BANKS = NUM_PINS / BANK_W;

    logic [NUM_PINS-1:0] mode_ok;
    logic [NUM_PINS-1:0] route_ok;
    logic                wr_status;
    logic                wr_enable;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_q
        assign mode_ok[p]  = (pin_trig_mode[2*p +: 2] == TRIG_LEVEL) ||
                             (pin_trig_mode[2*p +: 2] == TRIG_RISE);
        assign route_ok[p] = (pin_route_sel[SEL_W*p +: SEL_W] != '0);
    end

    // Any write landing in the status or enable window.
    always_comb begin
        wr_status = 1'b0;
        wr_enable = 1'b0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (bus_wr && bus_addr == ADDR_W'(STATUS_BASE + WORD_BYTES * k)) wr_status = 1'b1;
            if (bus_wr && bus_addr == ADDR_W'(ENABLE_BASE + WORD_BYTES * k)) wr_enable = 1'b1;
        end
    end

    p_irq_follows_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(status_all & enable_all))));

    p_off_mode_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_all & ~$past(status_all) & ~$past(mode_ok)) == '0));

    p_no_route_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_all & ~$past(status_all) & ~$past(route_ok)) == '0));

    p_clear_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_all) & ~status_all) == '0) || $past(wr_status)));

    p_enable_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(enable_all) || $past(wr_enable)));

endmodule

bind gpio_irq_aggregator gpio_irq_aggregator_sva #(
    .NUM_PINS (NUM_PINS),
    .BANK_W   (BANK_W),
    .SEL_W    (SEL_W),
    .ADDR_W   (ADDR_W)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .irq_out       (irq_out),
    .status_all    (status_all),
    .enable_all    (enable_all),
    .pin_trig_mode (pin_trig_mode),
    .pin_route_sel (pin_route_sel)
);

// File: tb/gpio_irq_aggregator_test.sv
`timescale 1ns/1ps
module gpio_irq_aggregator_test;

    localparam int NP = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0]   level = '0;
    logic [2*NP-1:0] mode = {NP{2'd2}};
    logic [8*NP-1:0] route = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_aggregator uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_level     (level),
        .pin_trig_mode (mode),
        .pin_route_sel (route),
        .bus_wr        (wr),
        .bus_rd        (rd),
        .bus_addr      (addr),
        .bus_wdata     (wdata),
        .bus_rdata     (rdata),
        .irq_out       (irq)
    );

    typedef struct packed {
        logic [6:0] pin;
        logic [1:0] md;
        logic [7:0] rs;
        logic       en;
        logic       exp_st;
        logic       exp_irq;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{7'd0,   2'd1, 8'h01, 1'b1, 1'b1, 1'b1},  // R4 rising
        '{7'd31,  2'd0, 8'h80, 1'b1, 1'b1, 1'b1},  // R3 level
        '{7'd32,  2'd2, 8'h05, 1'b1, 1'b0, 1'b0},  // R5 mode 2
        '{7'd63,  2'd3, 8'h05, 1'b1, 1'b0, 1'b0},  // R5 mode 3
        '{7'd64,  2'd1, 8'h00, 1'b1, 1'b0, 1'b0},  // R6 no route
        '{7'd95,  2'd0, 8'h00, 1'b1, 1'b0, 1'b0},  // R6 no route
        '{7'd96,  2'd1, 8'h02, 1'b0, 1'b1, 1'b0},  // R9 masked
        '{7'd127, 2'd0, 8'hff, 1'b0, 1'b1, 1'b0},  // R9 masked
        '{7'd100, 2'd1, 8'h03, 1'b1, 1'b1, 1'b1},  // R2 bank 3
        '{7'd45,  2'd0, 8'h01, 1'b1, 1'b1, 1'b1}   // R2 bank 1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        d = rdata; rd = 1'b0;
    endtask

    task automatic cfg_pin(input int p, input logic [1:0] m, input logic [7:0] r);
        mode[2*p +: 2] = m;
        route[8*p +: 8] = r;
    endtask

    task automatic pulse(input int p);
        @(negedge clk) level[p] = 1'b1;
        @(negedge clk) level[p] = 1'b0;
    endtask

    function automatic logic [7:0] st_addr(input int p);
        return 8'(8'h14 + 4 * (p / 32));
    endfunction

    function automatic logic [7:0] en_addr(input int p);
        return 8'(8'h24 + 4 * (p / 32));
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        bus_read(8'h14, d); chk("R1 status0", d, 32'd0);
        bus_read(8'h30, d); chk("R1 enable3", d, 32'd0);

        // Vector table walk
        foreach (VECS[i]) begin
            int p;
            p = int'(VECS[i].pin);
            cfg_pin(p, VECS[i].md, VECS[i].rs);
            if (VECS[i].en) bus_write(en_addr(p), 32'd1 << (p % 32));
            pulse(p);
            @(negedge clk);
            chk($sformatf("R10 vec%0d irq", i), {31'd0, irq}, {31'd0, VECS[i].exp_irq});
            bus_read(st_addr(p), d);
            chk($sformatf("R2/R3/R4/R5/R6 vec%0d status", i), d,
                VECS[i].exp_st ? (32'd1 << (p % 32)) : 32'd0);
            bus_write(st_addr(p), 32'hffff_ffff);
            bus_write(en_addr(p), 32'd0);
            cfg_pin(p, 2'd2, 8'd0);
            repeat (2) @(negedge clk);
        end

        // R2: enable readback and unmapped addresses
        bus_write(8'h2C, 32'hA5A5_0001);
        bus_read(8'h2C, d); chk("R2 enable2 readback", d, 32'hA5A5_0001);
        bus_write(8'h2C, 32'd0);
        bus_write(8'h34, 32'hffff_ffff);
        bus_read(8'h30, d); chk("R2 unmapped write ignored", d, 32'd0);
        bus_read(8'h34, d); chk("R2 unmapped read 0x34", d, 32'd0);
        bus_read(8'h00, d); chk("R2 unmapped read 0x00", d, 32'd0);

        // R10: irq lags status by exactly one cycle
        cfg_pin(9, 2'd1, 8'h01);
        bus_write(8'h24, 32'd1 << 9);
        @(negedge clk) level[9] = 1'b1;
        @(negedge clk);
        chk("R10 irq not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R10 irq raised", {31'd0, irq}, 32'd1);
        level[9] = 1'b0;
        bus_write(8'h14, 32'd1 << 9);
        bus_write(8'h24, 32'd0);
        cfg_pin(9, 2'd2, 8'd0);
        repeat (2) @(negedge clk);
        chk("R10 irq dropped", {31'd0, irq}, 32'd0);

        // R7: write-one-to-clear, zeros ignored
        cfg_pin(5, 2'd1, 8'h01);
        pulse(5);
        bus_write(8'h14, 32'd0);
        bus_read(8'h14, d); chk("R7 write zero keeps", d, 32'd1 << 5);
        bus_write(8'h14, ~(32'd1 << 5));
        bus_read(8'h14, d); chk("R7 other ones keep", d, 32'd1 << 5);
        bus_write(8'h14, 32'd1 << 5);
        bus_read(8'h14, d); chk("R7 one clears", d, 32'd0);
        cfg_pin(5, 2'd2, 8'd0);

        // R8: set wins over simultaneous clear; R4: steady high no re-set
        cfg_pin(6, 2'd1, 8'h01);
        pulse(6);
        @(negedge clk);
        level[6] = 1'b1; wr = 1'b1; addr = 8'h14; wdata = 32'd1 << 6;
        @(negedge clk);
        wr = 1'b0;
        bus_read(8'h14, d); chk("R8 set beats clear", d, 32'd1 << 6);
        bus_write(8'h14, 32'd1 << 6);
        bus_read(8'h14, d); chk("R4 steady high no re-set", d, 32'd0);
        level[6] = 1'b0;
        cfg_pin(6, 2'd2, 8'd0);

        // R11: level mode clear while high does not stick
        cfg_pin(7, 2'd0, 8'h01);
        @(negedge clk) level[7] = 1'b1;
        bus_write(8'h14, 32'd1 << 7);
        bus_read(8'h14, d); chk("R11 clear while high", d, 32'd1 << 7);
        @(negedge clk) level[7] = 1'b0;
        bus_write(8'h14, 32'd1 << 7);
        bus_read(8'h14, d); chk("R11 clear after fall", d, 32'd0);
        cfg_pin(7, 2'd2, 8'd0);

        // R9: masking keeps status, unmasking restores irq
        cfg_pin(40, 2'd1, 8'h01);
        bus_write(8'h28, 32'd1 << 8);
        pulse(40);
        @(negedge clk);
        chk("R9 irq enabled", {31'd0, irq}, 32'd1);
        bus_write(8'h28, 32'd0);
        @(negedge clk);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        bus_read(8'h18, d); chk("R9 status retained", d, 32'd1 << 8);
        bus_read(8'h28, d); chk("R9 enable cleared", d, 32'd0);
        bus_write(8'h28, 32'd1 << 8);
        @(negedge clk);
        chk("R9 irq on unmask", {31'd0, irq}, 32'd1);
        bus_write(8'h18, 32'd1 << 8);
        bus_write(8'h28, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule